// File: doc/BRIEF.md
# Serial Flash Push-Button Self-Test Sequencer

This block is the control front end of a flash bring-up test. It sits between three debounced push-button levels and a byte-wide SPI master engine and drives a serial NOR flash through a fixed routine. One button writes a five-byte pattern to a fixed address window. A second button reads that window back and compares it with the pattern. The third button erases the whole chip. The verify outcome appears on four LEDs: a steady pattern for a match, and all four LEDs flashing together for a mismatch.

The byte engine is told to move one byte at a time. The sequencer raises `spi_go` with the byte on `spi_tx`, and the engine answers with a one-cycle `spi_done` and the byte it clocked in on `spi_rx`. The sequencer owns the chip select. It builds every command frame: write enable, program, read, chip erase and status read. After a program or an erase it keeps reading the status register until the busy bit clears. It applies no timeout, because a chip erase can run for minutes.

Top module: `flash_selftest`

## Requirements
- R1: While reset is high and directly after it, `spi_cs_n` is 1, `spi_go` is 0 and `led` is 4'b0000.
- R2: A rising edge on `btn_wr` produces two frames. The first is the single byte 0x06. The second is 0x02, then the 24-bit start address 0x050000 sent most significant byte first (05 00 00), then the pattern bytes A0 A1 A2 A3 A4.
- R3: A rising edge on `btn_rd` produces one frame: 0x03, then 05 00 00, then five 0x00 filler bytes. The five bytes received during the filler are compared in order with A0..A4.
- R4: When every compared byte matches, `led` becomes 4'b1010 in the second clock after `spi_cs_n` rises at the end of the read frame, and it then holds that value.
- R5: When any compared byte differs, all four LEDs toggle together between 4'b1111 and 4'b0000. Each phase lasts BLINK_CYC cycles.
- R6: A rising edge on `btn_er` produces the single-byte frame 0x06 and then the single-byte frame 0xC7.
- R7: After the program frame or the erase frame, the sequencer sends repeated two-byte frames 0x05 0x00. It repeats them while bit 0 of the second received byte is 1, with no limit on the count. It returns to idle after the first frame in which that bit is 0.
- R8: Chip select returns high for at least one cycle between frames. `spi_go` is raised only while `spi_cs_n` is low. No new byte is requested until `spi_done` has answered the previous one.
- R9: A button edge that arrives while an operation is running is discarded. A button held high starts exactly one operation.
- R10: When rising edges arrive in the same cycle, write wins over read and read wins over erase.
- R11: Starting a write or an erase sets `led` to 4'b0000.
- R12: A read after a chip erase reports a mismatch (R5), because the window then reads as 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| btn_wr | input | 1 | Debounced level of the write button |
| btn_rd | input | 1 | Debounced level of the verify button |
| btn_er | input | 1 | Debounced level of the erase button |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_go | output | 1 | One-cycle request to shift `spi_tx` |
| spi_tx | output | 8 | Byte to be shifted out |
| spi_done | input | 1 | One-cycle pulse: the byte engine finished a byte |
| spi_rx | input | 8 | Byte received during that transfer, valid with `spi_done` |
| led | output | 4 | Result display |

## Verification
A button edge is registered once, so chip select falls two clocks after the input rises. The first `spi_go` follows one clock later. Each byte after that waits for `spi_done`, and frames are therefore compared whole when chip select rises, not byte by byte at fixed offsets. The LED display is sampled at the falling edge of the second clock after the read frame closes, which is when the registered result reaches the pins. Blinking is judged by the lengths of the constant runs over four periods. Discarded presses are judged by the absence of any frame that the scoreboard did not expect.

// File: rtl/fst_pkg.sv
package fst_pkg;
  localparam logic [7:0] OPC_WREN  = 8'h06;
  localparam logic [7:0] OPC_PROG  = 8'h02;
  localparam logic [7:0] OPC_READ  = 8'h03;
  localparam logic [7:0] OPC_ERASE = 8'hC7;
  localparam logic [7:0] OPC_RDSR  = 8'h05;

  typedef enum logic [2:0] {S_IDLE, S_WREN, S_GAP, S_MAIN, S_POLL} st_e;
  typedef enum logic [1:0] {OP_PROG, OP_READ, OP_ERASE} op_e;
  typedef enum logic [1:0] {RES_NONE, RES_PASS, RES_FAIL} res_e;

  // number of bytes in the frame issued from state s
  function automatic int frame_len(st_e s, op_e o, int n);
    if (s == S_WREN) return 1;
    if (s == S_POLL) return 2;
    if (o == OP_ERASE) return 1;
    return 4 + n;
  endfunction

  // byte i of the frame issued from state s
  function automatic logic [7:0] frame_byte(st_e s, op_e o, int i,
                                            logic [23:0] a, logic [7:0] pb);
    if (s == S_WREN) return OPC_WREN;
    if (s == S_POLL) return (i == 0) ? OPC_RDSR : 8'h00;
    if (i == 0) begin
      case (o)
        OP_PROG: return OPC_PROG;
        OP_READ: return OPC_READ;
        default: return OPC_ERASE;
      endcase
    end
    if (i == 1) return a[23:16];
    if (i == 2) return a[15:8];
    if (i == 3) return a[7:0];
    if (o == OP_PROG) return pb + 8'(i - 4);
    return 8'h00;
  endfunction
endpackage

// File: rtl/fst_edge.sv
module fst_edge #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev   <= '0;
      rise_o <= '0;
    end else begin
      prev   <= lvl_i;
      rise_o <= lvl_i & ~prev;
    end
  end
endmodule

// File: rtl/fst_led.sv
module fst_led
  import fst_pkg::*;
#(
  parameter int BLINK_CYC = 25_000_000
) (
  input  logic       clk,
  input  logic       rst,
  input  res_e       res_i,
  output logic [3:0] led_o
);
  localparam int CW = $clog2(BLINK_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(BLINK_CYC - 1);
  localparam logic [3:0] PASS_PAT = 4'b1010;

  logic [CW-1:0] cnt;
  logic          ph;

  always_ff @(posedge clk) begin
    if (rst || res_i != RES_FAIL) begin
      cnt <= '0;
      ph  <= 1'b0;
    end else if (cnt == LAST) begin
      cnt <= '0;
      ph  <= ~ph;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) led_o <= 4'b0000;
    else begin
      case (res_i)
        RES_PASS: led_o <= PASS_PAT;
        RES_FAIL: led_o <= ph ? 4'b0000 : 4'b1111;
        default:  led_o <= 4'b0000;
      endcase
    end
  end
endmodule

// File: rtl/flash_selftest.sv
module flash_selftest
  import fst_pkg::*;
#(
  parameter int          NBYTES     = 5,
  parameter logic [23:0] START_ADDR = 24'h050000,
  parameter logic [7:0]  PAT_BASE   = 8'hA0,
  parameter int          BLINK_CYC  = 25_000_000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       btn_wr,
  input  logic       btn_rd,
  input  logic       btn_er,
  output logic       spi_cs_n,
  output logic       spi_go,
  output logic [7:0] spi_tx,
  input  logic       spi_done,
  input  logic [7:0] spi_rx,
  output logic [3:0] led
);
  localparam int IW = $clog2(NBYTES + 5);
  localparam logic [IW-1:0] HDR = IW'(4);

  logic [2:0]    rise;
  st_e           st, nxt;
  op_e           op;
  logic [IW-1:0] idx, flen;
  logic          pend, miss, wip;
  res_e          res;
  logic [7:0]    fbyte;

  fst_edge #(.N(3)) u_edge (
    .clk   (clk),
    .rst   (rst),
    .lvl_i ({btn_er, btn_rd, btn_wr}),
    .rise_o(rise)
  );

  always_comb begin
    flen  = IW'(frame_len(st, op, NBYTES));
    fbyte = frame_byte(st, op, int'(idx), START_ADDR, PAT_BASE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      nxt      <= S_IDLE;
      op       <= OP_READ;
      idx      <= '0;
      pend     <= 1'b0;
      miss     <= 1'b0;
      wip      <= 1'b0;
      res      <= RES_NONE;
      spi_cs_n <= 1'b1;
      spi_go   <= 1'b0;
      spi_tx   <= '0;
    end else begin
      spi_go <= 1'b0;
      case (st)
        S_IDLE: begin
          if (|rise) begin
            idx      <= '0;
            pend     <= 1'b0;
            miss     <= 1'b0;
            spi_cs_n <= 1'b0;
            if (rise[0]) begin
              op  <= OP_PROG;
              st  <= S_WREN;
              res <= RES_NONE;
            end else if (rise[1]) begin
              op <= OP_READ;
              st <= S_MAIN;
            end else begin
              op  <= OP_ERASE;
              st  <= S_WREN;
              res <= RES_NONE;
            end
          end
        end
        S_GAP: begin
          idx      <= '0;
          spi_cs_n <= 1'b0;
          st       <= nxt;
        end
        default: begin
          if (pend) begin
            if (spi_done) begin
              pend <= 1'b0;
              idx  <= idx + 1'b1;
              if (st == S_MAIN && op == OP_READ && idx >= HDR &&
                  spi_rx != PAT_BASE + 8'(idx - HDR))
                miss <= 1'b1;
              if (st == S_POLL && idx == IW'(1))
                wip <= spi_rx[0];
            end
          end else if (idx != flen) begin
            spi_go <= 1'b1;
            spi_tx <= fbyte;
            pend   <= 1'b1;
          end else begin
            spi_cs_n <= 1'b1;
            if (st == S_WREN) begin
              st  <= S_GAP;
              nxt <= S_MAIN;
            end else if (st == S_MAIN && op == OP_READ) begin
              st  <= S_IDLE;
              res <= miss ? RES_FAIL : RES_PASS;
            end else if (st == S_MAIN) begin
              st  <= S_GAP;
              nxt <= S_POLL;
            end else if (wip) begin
              st  <= S_GAP;
              nxt <= S_POLL;
            end else begin
              st <= S_IDLE;
            end
          end
        end
      endcase
    end
  end

  fst_led #(.BLINK_CYC(BLINK_CYC)) u_led (
    .clk  (clk),
    .rst  (rst),
    .res_i(res),
    .led_o(led)
  );
endmodule

// File: rtl/fst_chk.sv
module fst_chk (
  input logic       clk,
  input logic       rst,
  input logic       spi_cs_n,
  input logic       spi_go,
  input logic       spi_done,
  input logic [3:0] led
);
  logic pend_q;

  always_ff @(posedge clk) begin
    if (rst)           pend_q <= 1'b0;
    else if (spi_go)   pend_q <= 1'b1;
    else if (spi_done) pend_q <= 1'b0;
  end

  assert_go_selected_R8: assert property (@(posedge clk) disable iff (rst)
    spi_go |-> !spi_cs_n);

  assert_one_in_flight_R8: assert property (@(posedge clk) disable iff (rst)
    spi_go |-> !pend_q);

  assert_release_idle_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(spi_cs_n) |-> !pend_q);

  assert_led_legal_R5: assert property (@(posedge clk) disable iff (rst)
    (led == 4'b0000 || led == 4'b1010 || led == 4'b1111));

  assert_pass_steady_R4: assert property (@(posedge clk) disable iff (rst)
    (led == 4'b1010) |=> (led == 4'b1010 || led == 4'b0000));
endmodule

bind flash_selftest fst_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .spi_cs_n(spi_cs_n),
  .spi_go  (spi_go),
  .spi_done(spi_done),
  .led     (led)
);

// File: tb/sim_flash_selftest.sv
module sim_flash_selftest;
  localparam int BLINK = 8;
  localparam int LAT = 3;
  localparam int PROG_POLLS = 3;
  localparam int ERASE_POLLS = 25;

  logic clk = 1'b0, rst = 1'b1;
  logic btn_wr = 1'b0, btn_rd = 1'b0, btn_er = 1'b0;
  logic spi_cs_n, spi_go, spi_done = 1'b0;
  logic [7:0] spi_tx, spi_rx = 8'h00;
  logic [3:0] led;

  always #2.5 clk = ~clk;

  flash_selftest #(.BLINK_CYC(BLINK)) u0 (
    .clk(clk), .rst(rst), .btn_wr(btn_wr), .btn_rd(btn_rd), .btn_er(btn_er),
    .spi_cs_n(spi_cs_n), .spi_go(spi_go), .spi_tx(spi_tx),
    .spi_done(spi_done), .spi_rx(spi_rx), .led(led)
  );

  int n_chk = 0, n_fail = 0;

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // ---------------- scoreboard ----------------
  typedef struct { logic [127:0] v; int n; string tag; } fr_t;
  fr_t expq[$];

  task automatic exp_push(string tag, int n, logic [127:0] v);
    fr_t f;
    f.v = v; f.n = n; f.tag = tag;
    expq.push_back(f);
  endtask

  task automatic exp_polls(int cnt);
    for (int k = 0; k <= cnt; k++) exp_push("R7", 2, 128'h0005);
  endtask

  task automatic exp_prog();
    logic [127:0] v = '0;
    exp_push("R2", 1, 128'h06);
    v[7:0] = 8'h02; v[15:8] = 8'h05; v[23:16] = 8'h00; v[31:24] = 8'h00;
    for (int k = 0; k < 5; k++) v[8*(4+k) +: 8] = 8'hA0 + 8'(k);
    exp_push("R2", 9, v);
    exp_polls(PROG_POLLS);
  endtask

  task automatic exp_read();
    exp_push("R3", 9, 128'h0000_0000_0000_0503);
  endtask

  task automatic exp_erase();
    exp_push("R6", 1, 128'h06);
    exp_push("R6", 1, 128'hC7);
    exp_polls(ERASE_POLLS);
  endtask

  // ---------------- flash + byte engine model ----------------
  logic [7:0] mem [int];
  logic [7:0] fr [16];
  int fn = 0, busy = 0, wip = 0;
  logic wel = 1'b0, prev_cs = 1'b1;
  logic [7:0] rx_hold = 8'h00;

  function automatic logic [7:0] mem_rd(int a);
    return mem.exists(a) ? mem[a] : 8'hFF;
  endfunction

  function automatic logic [7:0] rx_for(int k);
    int a;
    a = {8'h00, fr[1], fr[2], fr[3]};
    if (fr[0] == 8'h03 && k >= 4) return mem_rd(a + k - 4);
    if (fr[0] == 8'h05 && k >= 1) return {7'b0, wip > 0};
    return 8'hFF;
  endfunction

  task automatic end_frame();
    fr_t e;
    int a;
    logic ok;
    if (expq.size() == 0) begin
      chk("R9", fn, 0);
    end else begin
      e = expq.pop_front();
      ok = (fn == e.n);
      for (int k = 0; k < 16; k++)
        if (k < fn && fr[k] != e.v[8*k +: 8]) ok = 1'b0;
      n_chk++;
      if (!ok) begin
        n_fail++;
        $display("FAIL %s: frame len %0d first %0h, expected len %0d first %0h",
                 e.tag, fn, fr[0], e.n, e.v[7:0]);
      end
    end
    a = {8'h00, fr[1], fr[2], fr[3]};
    if (fn == 1 && fr[0] == 8'h06) wel = 1'b1;
    else if (fn > 4 && fr[0] == 8'h02 && wel) begin
      for (int k = 4; k < fn; k++) mem[a + k - 4] = mem_rd(a + k - 4) & fr[k];
      wel = 1'b0; wip = PROG_POLLS;
    end else if (fn == 1 && fr[0] == 8'hC7 && wel) begin
      mem.delete(); wel = 1'b0; wip = ERASE_POLLS;
    end else if (fr[0] == 8'h05 && wip > 0) wip--;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      spi_done = 1'b0;
      if (busy > 0) begin
        busy--;
        if (busy == 0) begin spi_done = 1'b1; spi_rx = rx_hold; end
      end
      if (!rst && spi_go) begin
        if (fn < 16) fr[fn] = spi_tx;
        rx_hold = rx_for(fn);
        fn++;
        busy = LAT;
      end
      if (!rst && !prev_cs && spi_cs_n) end_frame();
      if (prev_cs && !spi_cs_n) fn = 0;
      prev_cs = spi_cs_n;
    end
  end

  // ---------------- helpers ----------------
  task automatic press(ref logic b, input int hold);
    @(negedge clk); b = 1'b1;
    repeat (hold) @(negedge clk);
    b = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (expq.size() != 0 || !spi_cs_n);
  endtask

  task automatic chk_blink(string req);
    int changes = 0, bad = 0, run = 0, illegal = 0;
    logic [3:0] last;
    @(negedge clk); last = led;
    for (int c = 0; c < 4 * BLINK; c++) begin
      @(negedge clk);
      if (led != 4'h0 && led != 4'hF) illegal++;
      run++;
      if (led != last) begin
        if (changes > 0 && run != BLINK) bad++;
        changes++; run = 0; last = led;
      end
    end
    chk(req, changes >= 3, 1);
    chk(req, bad, 0);
    chk(req, illegal, 0);
  endtask

  task automatic chk_steady(string req, logic [3:0] val);
    int bad = 0;
    for (int c = 0; c < 4 * BLINK; c++) begin
      @(negedge clk);
      if (led != val) bad++;
    end
    chk(req, bad, 0);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    repeat (4) @(negedge clk);
    chk("R1", spi_cs_n, 1); chk("R1", spi_go, 0); chk("R1", led, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", spi_cs_n, 1); chk("R1", led, 0);

    // verify on blank flash -> mismatch, blink (R3, R5)
    exp_read();
    press(btn_rd, 2);
    wait_idle();
    chk_blink("R5");

    // write pattern, LEDs cleared (R2, R7, R11)
    exp_prog();
    press(btn_wr, 2);
    wait_idle();
    @(negedge clk); @(negedge clk);
    chk("R11", led, 0);

    // verify -> pass, 1010 two clocks after select rises (R4)
    exp_read();
    press(btn_rd, 2);
    wait_idle();
    chk("R4", led, 0);
    @(negedge clk);
    chk("R4", led, 4'b1010);
    chk_steady("R4", 4'b1010);

    // erase, with a write press during the busy polling (R6, R7, R9, R11)
    exp_erase();
    press(btn_er, 2);
    repeat (80) @(negedge clk);
    chk("R9", spi_cs_n == 1 && expq.size() == 0, 0);
    press(btn_wr, 3);
    wait_idle();
    repeat (30) @(negedge clk);
    chk("R9", expq.size(), 0);
    chk("R11", led, 0);

    // read after erase must fail (R12)
    exp_read();
    press(btn_rd, 2);
    wait_idle();
    chk_blink("R12");

    // write and read pressed together: write wins (R10)
    exp_prog();
    @(negedge clk); btn_wr = 1'b1; btn_rd = 1'b1;
    repeat (2) @(negedge clk);
    btn_wr = 1'b0; btn_rd = 1'b0;
    wait_idle();
    repeat (30) @(negedge clk);
    chk("R10", expq.size(), 0);
    chk("R11", led, 0);

    // held verify button: exactly one read, passes (R9, R4)
    exp_read();
    press(btn_rd, 300);
    repeat (30) @(negedge clk);
    chk("R9", expq.size(), 0);
    chk("R4", led, 4'b1010);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule